// File: doc/BRIEF.md
# Single-Cycle Integer Processor Core

This block is a compact processor that completes one 32-bit instruction on every clock edge. It fetches through an instruction port whose address is the program counter, and it reads and writes data through a byte-addressed data port with per-lane enables. Both memories must answer combinationally within the same cycle. The core executes a load-store integer subset: add, subtract, add-immediate, signed set-less-than (register and immediate), load-upper-immediate, word and byte loads and stores, equal and not-equal branches, absolute jump, jump-with-link and jump-through-register.

Instruction words come in three formats, and the top six bits (the opcode) choose among them. The register-register form carries source fields rs [25:21] and rt [20:16], a destination rd [15:11], a shift field [10:6] and a function code [5:0]. The immediate form carries rs, rt and a 16-bit immediate [15:0]. The jump form carries a 26-bit word target [25:0]. There are 32 general registers of 32 bits each, and register 0 is hardwired to zero. The only memory addressing mode is base register plus sign-extended displacement. A separate sequencing unit owns the program counter and picks the next address.

Top module: `sc_core`

## Requirements
- R1: While rst_n is low the program counter is held at RESET_PC (default 0) and no store is issued. All registers read zero after reset.
- R2: Any instruction that does not transfer control advances the fetch address by 4.
- R3: add (opcode 0, funct 32) writes rs+rt to rd, sub (opcode 0, funct 34) writes rs-rt to rd, and addi (opcode 8) writes rs plus the sign-extended immediate to rt. All three wrap modulo 2^32.
- R4: slt (opcode 0, funct 42) and slti (opcode 10) write 1 when the first operand is less than the second in a signed comparison, and 0 otherwise. slti sign-extends its immediate.
- R5: lui (opcode 15) writes the immediate to rt bits [31:16] and zeros to bits [15:0].
- R6: Register 0 always reads as zero, and writes to it are discarded.
- R7: lw (opcode 35) and sw (opcode 43) use the address rs + sign-extended immediate, drive dmem_be = 4'b1111, and store the rt value unchanged.
- R8: lb (opcode 32) and sb (opcode 40) select byte lane addr[1:0] in little-endian order (lane 0 is bits [7:0]). lb sign-extends the loaded byte. sb drives only the enable of that lane and replicates rt[7:0] on all four lanes.
- R9: beq (opcode 4) and bne (opcode 5) branch to PC+4 + (sign-extended immediate × 4) when rs==rt or rs!=rt respectively, and otherwise fall through to PC+4.
- R10: j (opcode 2) and jal (opcode 3) go to {PC+4[31:28], target, 2'b00}. jal also writes PC+4 to register 31 in the same cycle.
- R11: jr (opcode 0, funct 8) loads the rs value into the program counter.
- R12: An unknown opcode, an unknown funct, or an opcode-0 word with a nonzero shift field writes no register and no memory, and behaves like a step of PC+4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Fetch address (program counter) |
| imem_rdata | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | 32 | Byte address of the data access |
| dmem_wdata | output | 32 | Store data |
| dmem_be | output | 4 | Byte-lane enables of the access |
| dmem_we | output | 1 | Store strobe, written at the rising edge |
| dmem_rdata | input | 32 | Load data at dmem_addr, same cycle |

## Verification
The sharpest overlap is jump-with-link: one clock edge both writes PC+4 into register 31 and redirects the program counter. The return then reads that fresh link register on the very next instruction. A hand-encoded program calls a subroutine that first stores register 31 to memory and then returns through it. The bench judges the result from the fetch address right after the call, from the stored link value, and from the stores made after the return. It also reads a word that a skipped instruction would have changed. A second overlap, a byte store that must leave three lanes of a word untouched while the same cycle computes a displaced address, is judged by comparing the whole memory word against its preloaded neighbours.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

    localparam int XLEN = 32;

    localparam logic [5:0] OP_RTYPE = 6'd0;
    localparam logic [5:0] OP_J     = 6'd2;
    localparam logic [5:0] OP_JAL   = 6'd3;
    localparam logic [5:0] OP_BEQ   = 6'd4;
    localparam logic [5:0] OP_BNE   = 6'd5;
    localparam logic [5:0] OP_ADDI  = 6'd8;
    localparam logic [5:0] OP_SLTI  = 6'd10;
    localparam logic [5:0] OP_LUI   = 6'd15;
    localparam logic [5:0] OP_LB    = 6'd32;
    localparam logic [5:0] OP_LW    = 6'd35;
    localparam logic [5:0] OP_SB    = 6'd40;
    localparam logic [5:0] OP_SW    = 6'd43;

    localparam logic [5:0] FN_JR    = 6'd8;
    localparam logic [5:0] FN_ADD   = 6'd32;
    localparam logic [5:0] FN_SUB   = 6'd34;
    localparam logic [5:0] FN_SLT   = 6'd42;

    localparam logic [4:0] LINK_REG = 5'd31;

    typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_SLT, ALU_LUI} alu_op_e;
    typedef enum logic [1:0] {WB_ALU, WB_WORD, WB_BYTE, WB_LINK} wb_sel_e;
    typedef enum logic [2:0] {SEQ_NEXT, SEQ_BEQ, SEQ_BNE, SEQ_JUMP, SEQ_JREG} seq_e;

    typedef struct packed {
        alu_op_e    alu_op;
        logic       use_imm;
        logic       reg_we;
        logic [4:0] dst;
        wb_sel_e    wb_sel;
        logic       mem_access;
        logic       mem_byte;
        logic       mem_we;
        seq_e       seq;
        logic       illegal;
    } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_core_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] funct,
    input  logic [4:0] shamt,
    input  logic [4:0] rt,
    input  logic [4:0] rd,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_ADD;
        ctrl.wb_sel = WB_ALU;
        ctrl.seq    = SEQ_NEXT;
        ctrl.dst    = rt;
        case (op)
            OP_RTYPE: begin
                ctrl.dst = rd;
                if (shamt != 5'd0) begin
                    ctrl.illegal = 1'b1;
                end else begin
                    case (funct)
                        FN_ADD: ctrl.reg_we = 1'b1;
                        FN_SUB: begin
                            ctrl.alu_op = ALU_SUB;
                            ctrl.reg_we = 1'b1;
                        end
                        FN_SLT: begin
                            ctrl.alu_op = ALU_SLT;
                            ctrl.reg_we = 1'b1;
                        end
                        FN_JR:   ctrl.seq     = SEQ_JREG;
                        default: ctrl.illegal = 1'b1;
                    endcase
                end
            end
            OP_ADDI: begin
                ctrl.use_imm = 1'b1;
                ctrl.reg_we  = 1'b1;
            end
            OP_SLTI: begin
                ctrl.use_imm = 1'b1;
                ctrl.alu_op  = ALU_SLT;
                ctrl.reg_we  = 1'b1;
            end
            OP_LUI: begin
                ctrl.use_imm = 1'b1;
                ctrl.alu_op  = ALU_LUI;
                ctrl.reg_we  = 1'b1;
            end
            OP_LW, OP_LB: begin
                ctrl.use_imm    = 1'b1;
                ctrl.mem_access = 1'b1;
                ctrl.reg_we     = 1'b1;
                ctrl.mem_byte   = (op == OP_LB);
                ctrl.wb_sel     = (op == OP_LB) ? WB_BYTE : WB_WORD;
            end
            OP_SW, OP_SB: begin
                ctrl.use_imm    = 1'b1;
                ctrl.mem_access = 1'b1;
                ctrl.mem_we     = 1'b1;
                ctrl.mem_byte   = (op == OP_SB);
            end
            OP_BEQ: ctrl.seq = SEQ_BEQ;
            OP_BNE: ctrl.seq = SEQ_BNE;
            OP_J:   ctrl.seq = SEQ_JUMP;
            OP_JAL: begin
                ctrl.seq    = SEQ_JUMP;
                ctrl.reg_we = 1'b1;
                ctrl.dst    = LINK_REG;
                ctrl.wb_sel = WB_LINK;
            end
            default: ctrl.illegal = 1'b1;
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int NREG  = 32,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    ra_a,
    input  logic [AW-1:0]    ra_b,
    output logic [WIDTH-1:0] rd_a,
    output logic [WIDTH-1:0] rd_b,
    input  logic             we,
    input  logic [AW-1:0]    wa,
    input  logic [WIDTH-1:0] wd
);

    logic [WIDTH-1:0] regs_d [NREG];
    logic [WIDTH-1:0] regs_q [NREG];

    always_comb begin
        regs_d = regs_q;
        if (we && (wa != '0)) begin
            regs_d[wa] = wd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd_a = (ra_a == '0) ? '0 : regs_q[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs_q[ra_b];

endmodule

// File: rtl/sc_seq.sv
module sc_seq
    import sc_core_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  seq_e            kind,
    input  logic            ops_equal,
    input  logic [15:0]     imm16,
    input  logic [25:0]     target,
    input  logic [XLEN-1:0] reg_target,
    output logic [XLEN-1:0] pc_q,
    output logic [XLEN-1:0] pc_plus4
);

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } seq_state_t;

    seq_state_t      state_d, state_q;
    logic [XLEN-1:0] br_tgt;

    assign pc_q     = state_q.pc;
    assign pc_plus4 = state_q.pc + XLEN'(4);
    assign br_tgt   = pc_plus4 + {{(XLEN-18){imm16[15]}}, imm16, 2'b00};

    always_comb begin
        state_d.pc = pc_plus4;
        case (kind)
            SEQ_BEQ:  if (ops_equal)  state_d.pc = br_tgt;
            SEQ_BNE:  if (!ops_equal) state_d.pc = br_tgt;
            SEQ_JUMP: state_d.pc = {pc_plus4[XLEN-1:28], target, 2'b00};
            SEQ_JREG: state_d.pc = reg_target;
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.pc <= RESET_PC;
        end else begin
            state_q <= state_d;
        end
    end

    p_plain_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == SEQ_NEXT) |=> (pc_q == $past(pc_q) + XLEN'(4)));

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_core_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_0000,
    parameter int          NREG     = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_rdata,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    output logic [3:0]  dmem_be,
    output logic        dmem_we,
    input  logic [31:0] dmem_rdata
);

    localparam int RAW = $clog2(NREG);

    ctrl_t           ctrl;
    logic [4:0]      rs_idx, rt_idx;
    logic [XLEN-1:0] rs_val, rt_val, simm, opb, alu_res, wb_data;
    logic [XLEN-1:0] pc_q, pc_plus4;
    logic [1:0]      lane;
    logic [7:0]      ld_byte;

    assign rs_idx = imem_rdata[25:21];
    assign rt_idx = imem_rdata[20:16];
    assign simm   = {{(XLEN-16){imem_rdata[15]}}, imem_rdata[15:0]};

    sc_decode u_dec (
        .op    (imem_rdata[31:26]),
        .funct (imem_rdata[5:0]),
        .shamt (imem_rdata[10:6]),
        .rt    (rt_idx),
        .rd    (imem_rdata[15:11]),
        .ctrl  (ctrl)
    );

    sc_regfile #(.NREG(NREG), .WIDTH(XLEN)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra_a  (RAW'(rs_idx)),
        .ra_b  (RAW'(rt_idx)),
        .rd_a  (rs_val),
        .rd_b  (rt_val),
        .we    (ctrl.reg_we),
        .wa    (RAW'(ctrl.dst)),
        .wd    (wb_data)
    );

    sc_seq #(.RESET_PC(RESET_PC)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .kind       (ctrl.seq),
        .ops_equal  (rs_val == rt_val),
        .imm16      (imem_rdata[15:0]),
        .target     (imem_rdata[25:0]),
        .reg_target (rs_val),
        .pc_q       (pc_q),
        .pc_plus4   (pc_plus4)
    );

    assign opb = ctrl.use_imm ? simm : rt_val;

    always_comb begin
        case (ctrl.alu_op)
            ALU_SUB: alu_res = rs_val - opb;
            ALU_SLT: alu_res = {{(XLEN-1){1'b0}}, ($signed(rs_val) < $signed(opb))};
            ALU_LUI: alu_res = {opb[15:0], 16'h0000};
            default: alu_res = rs_val + opb;
        endcase
    end

    assign lane    = alu_res[1:0];
    assign ld_byte = dmem_rdata[8*lane +: 8];

    always_comb begin
        case (ctrl.wb_sel)
            WB_WORD: wb_data = dmem_rdata;
            WB_BYTE: wb_data = {{(XLEN-8){ld_byte[7]}}, ld_byte};
            WB_LINK: wb_data = pc_plus4;
            default: wb_data = alu_res;
        endcase
    end

    assign imem_addr  = pc_q;
    assign dmem_addr  = alu_res;
    assign dmem_we    = ctrl.mem_we && rst_n;
    assign dmem_wdata = ctrl.mem_byte ? {4{rt_val[7:0]}} : rt_val;
    assign dmem_be    = !ctrl.mem_access ? 4'b0000 :
                        ctrl.mem_byte    ? (4'b0001 << lane) : 4'b1111;

    p_zero_reg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_idx == 5'd0) |-> (rs_val == '0));

    p_word_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_rdata[31:26] == OP_SW) |-> (dmem_we && dmem_be == 4'b1111));

    p_byte_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_rdata[31:26] == OP_SB) |-> (dmem_we && $countones(dmem_be) == 1));

    p_link_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_rdata[31:26] == OP_JAL) |->
        (ctrl.reg_we && ctrl.dst == 5'd31 && wb_data == pc_q + 32'd4));

    p_unknown_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.illegal |-> (!ctrl.reg_we && !dmem_we));

endmodule

// File: tb/sc_core_test.sv
module sc_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_rdata;
    logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
    logic [3:0]  dmem_be;
    logic        dmem_we;

    logic [31:0] imem [0:63];
    logic [31:0] dmem [0:63];

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sc_core uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_be    (dmem_be),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) begin
        if (dmem_we) begin
            for (int b = 0; b < 4; b++) begin
                if (dmem_be[b]) dmem[dmem_addr[7:2]][8*b +: 8] <= dmem_wdata[8*b +: 8];
            end
        end
    end

    function automatic logic [31:0] enc_r(logic [5:0] fn, logic [4:0] rs, logic [4:0] rt,
                                          logic [4:0] rd, logic [4:0] sa);
        return {6'd0, rs, rt, rd, sa, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt,
                                          logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_j(logic [5:0] op, logic [25:0] tgt);
        return {op, tgt};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 64; i++) begin
            imem[i] = 32'h0;
            dmem[i] = 32'h0;
        end
    endtask

    task automatic release_reset();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic test_reset();
        hold_reset();
        imem[0]  = enc_i(6'd43, 5'd0, 5'd0, 16'd64);
        dmem[16] = 32'h0000_DEAD;
        @(negedge clk);
        chk("R1 pc in reset", imem_addr, 32'h0);
        chk("R1 no store in reset", {31'b0, dmem_we}, 32'h0);
        release_reset();
        #1 chk("R1 pc at release", imem_addr, 32'h0);
        chk("R1 memory untouched in reset", dmem[16], 32'h0000_DEAD);
        @(negedge clk);
        chk("R2 pc after one step", imem_addr, 32'd4);
        chk("R1 zero register file stored", dmem[16], 32'h0);
        repeat (2) @(negedge clk);
        chk("R2 pc after three steps", imem_addr, 32'd12);
    endtask

    task automatic test_arith();
        hold_reset();
        imem[0]  = enc_i(6'd8, 5'd0, 5'd1, 16'd7);
        imem[1]  = enc_i(6'd8, 5'd0, 5'd2, 16'hFFFD);
        imem[2]  = enc_r(6'd32, 5'd1, 5'd2, 5'd3, 5'd0);
        imem[3]  = enc_r(6'd34, 5'd2, 5'd1, 5'd4, 5'd0);
        imem[4]  = enc_r(6'd42, 5'd2, 5'd1, 5'd5, 5'd0);
        imem[5]  = enc_i(6'd10, 5'd1, 5'd6, 16'hFFFF);
        imem[6]  = enc_i(6'd15, 5'd0, 5'd7, 16'h8001);
        imem[7]  = enc_i(6'd8, 5'd1, 5'd0, 16'd5);
        imem[8]  = enc_r(6'd32, 5'd0, 5'd0, 5'd8, 5'd0);
        imem[9]  = enc_i(6'd15, 5'd0, 5'd9, 16'h7FFF);
        imem[10] = enc_r(6'd32, 5'd9, 5'd9, 5'd10, 5'd0);
        imem[11] = enc_r(6'd42, 5'd10, 5'd9, 5'd11, 5'd0);
        imem[12] = enc_i(6'd43, 5'd0, 5'd3, 16'd64);
        imem[13] = enc_i(6'd43, 5'd0, 5'd4, 16'd68);
        imem[14] = enc_i(6'd43, 5'd0, 5'd5, 16'd72);
        imem[15] = enc_i(6'd43, 5'd0, 5'd6, 16'd76);
        imem[16] = enc_i(6'd43, 5'd0, 5'd7, 16'd80);
        imem[17] = enc_i(6'd43, 5'd0, 5'd8, 16'd84);
        imem[18] = enc_i(6'd43, 5'd0, 5'd10, 16'd88);
        imem[19] = enc_i(6'd43, 5'd0, 5'd11, 16'd92);
        imem[20] = enc_j(6'd2, 26'd20);
        release_reset();
        repeat (30) @(negedge clk);
        chk("R3 add", dmem[16], 32'd4);
        chk("R3 sub negative", dmem[17], 32'hFFFF_FFF6);
        chk("R4 slt signed true", dmem[18], 32'd1);
        chk("R4 slti signed false", dmem[19], 32'd0);
        chk("R5 lui", dmem[20], 32'h8001_0000);
        chk("R6 write to zero discarded", dmem[21], 32'd0);
        chk("R3 add wraps", dmem[22], 32'hFFFE_0000);
        chk("R4 slt negative vs positive", dmem[23], 32'd1);
    endtask

    task automatic test_memory();
        hold_reset();
        dmem[14] = 32'hCAFE_F00D;
        dmem[15] = 32'hAABB_CCDD;
        dmem[16] = 32'h80FF_7F01;
        dmem[20] = 32'h1122_3344;
        imem[0]  = enc_i(6'd8, 5'd0, 5'd1, 16'd60);
        imem[1]  = enc_i(6'd35, 5'd1, 5'd2, 16'd4);
        imem[2]  = enc_i(6'd32, 5'd1, 5'd3, 16'd4);
        imem[3]  = enc_i(6'd32, 5'd1, 5'd4, 16'd5);
        imem[4]  = enc_i(6'd32, 5'd1, 5'd5, 16'd6);
        imem[5]  = enc_i(6'd32, 5'd1, 5'd6, 16'd7);
        imem[6]  = enc_i(6'd43, 5'd1, 5'd2, 16'd16);
        imem[7]  = enc_i(6'd40, 5'd1, 5'd6, 16'd21);
        imem[8]  = enc_i(6'd43, 5'd1, 5'd3, 16'd24);
        imem[9]  = enc_i(6'd43, 5'd1, 5'd4, 16'd28);
        imem[10] = enc_i(6'd43, 5'd1, 5'd5, 16'd32);
        imem[11] = enc_i(6'd43, 5'd1, 5'd6, 16'd36);
        imem[12] = enc_i(6'd35, 5'd1, 5'd7, 16'hFFFC);
        imem[13] = enc_i(6'd43, 5'd1, 5'd7, 16'd40);
        imem[14] = enc_i(6'd40, 5'd1, 5'd3, 16'd3);
        imem[15] = enc_j(6'd2, 26'd15);
        release_reset();
        repeat (25) @(negedge clk);
        chk("R7 lw then sw", dmem[19], 32'h80FF_7F01);
        chk("R8 lb lane0", dmem[21], 32'h0000_0001);
        chk("R8 lb lane1 positive", dmem[22], 32'h0000_007F);
        chk("R8 lb lane2 sign", dmem[23], 32'hFFFF_FFFF);
        chk("R8 lb lane3 sign", dmem[24], 32'hFFFF_FF80);
        chk("R8 sb lane1 only", dmem[20], 32'h1122_8044);
        chk("R8 sb lane3 only", dmem[15], 32'h01BB_CCDD);
        chk("R7 negative displacement", dmem[25], 32'hCAFE_F00D);
    endtask

    task automatic test_branch();
        hold_reset();
        imem[0]  = enc_i(6'd8, 5'd0, 5'd1, 16'd5);
        imem[1]  = enc_i(6'd8, 5'd0, 5'd2, 16'd5);
        imem[2]  = enc_i(6'd4, 5'd1, 5'd2, 16'd2);
        imem[3]  = enc_i(6'd8, 5'd0, 5'd3, 16'd1);
        imem[4]  = enc_i(6'd8, 5'd0, 5'd3, 16'd2);
        imem[5]  = enc_i(6'd5, 5'd1, 5'd2, 16'd1);
        imem[6]  = enc_i(6'd8, 5'd0, 5'd4, 16'd9);
        imem[7]  = enc_i(6'd8, 5'd0, 5'd5, 16'd3);
        imem[8]  = enc_i(6'd8, 5'd6, 5'd6, 16'd1);
        imem[9]  = enc_i(6'd8, 5'd5, 5'd5, 16'hFFFF);
        imem[10] = enc_i(6'd5, 5'd5, 5'd0, 16'hFFFD);
        imem[11] = enc_i(6'd43, 5'd0, 5'd3, 16'd64);
        imem[12] = enc_i(6'd43, 5'd0, 5'd4, 16'd68);
        imem[13] = enc_i(6'd43, 5'd0, 5'd6, 16'd72);
        imem[14] = enc_j(6'd2, 26'd14);
        dmem[16] = 32'hFFFF_FFFF;
        release_reset();
        repeat (3) @(negedge clk);
        chk("R9 beq taken target", imem_addr, 32'd20);
        repeat (40) @(negedge clk);
        chk("R9 beq skipped instructions", dmem[16], 32'd0);
        chk("R9 bne not taken falls through", dmem[17], 32'd9);
        chk("R9 bne backward loop count", dmem[18], 32'd3);
        chk("R9 halted at loop", imem_addr, 32'd56);
    endtask

    task automatic test_jump();
        hold_reset();
        imem[0] = enc_j(6'd3, 26'd5);
        imem[1] = enc_i(6'd43, 5'd0, 5'd2, 16'd68);
        imem[2] = enc_i(6'd43, 5'd0, 5'd10, 16'd72);
        imem[3] = enc_j(6'd2, 26'd3);
        imem[4] = enc_i(6'd8, 5'd0, 5'd10, 16'd99);
        imem[5] = enc_i(6'd8, 5'd0, 5'd2, 16'd11);
        imem[6] = enc_i(6'd43, 5'd0, 5'd31, 16'd64);
        imem[7] = enc_r(6'd8, 5'd31, 5'd0, 5'd0, 5'd0);
        dmem[18] = 32'h0000_1234;
        release_reset();
        @(negedge clk);
        chk("R10 jal target", imem_addr, 32'd20);
        repeat (3) @(negedge clk);
        chk("R11 jr returns to link", imem_addr, 32'd4);
        repeat (10) @(negedge clk);
        chk("R10 link value", dmem[16], 32'd4);
        chk("R11 code after return ran", dmem[17], 32'd11);
        chk("R10 skipped word not run", dmem[18], 32'd0);
        chk("R10 j holds at itself", imem_addr, 32'd12);
    endtask

    task automatic test_unknown();
        hold_reset();
        imem[0] = enc_i(6'd8, 5'd0, 5'd1, 16'd7);
        imem[1] = 32'hFC22_0040;
        imem[2] = enc_r(6'h3F, 5'd1, 5'd1, 5'd2, 5'd0);
        imem[3] = enc_r(6'd32, 5'd1, 5'd1, 5'd2, 5'd3);
        imem[4] = enc_i(6'd41, 5'd0, 5'd1, 16'd64);
        imem[5] = enc_i(6'd43, 5'd0, 5'd2, 16'd68);
        imem[6] = enc_j(6'd2, 26'd6);
        dmem[16] = 32'h5555_AAAA;
        dmem[17] = 32'h0000_FFFF;
        release_reset();
        repeat (5) @(negedge clk);
        chk("R12 unknown words step by 4", imem_addr, 32'd20);
        repeat (5) @(negedge clk);
        chk("R12 no memory write", dmem[16], 32'h5555_AAAA);
        chk("R12 no register write", dmem[17], 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            imem[i] = 32'h0;
            dmem[i] = 32'h0;
        end
        test_reset();
        test_arith();
        test_memory();
        test_branch();
        test_jump();
        test_unknown();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule